// File: doc/BRIEF.md
# Successive-Approximation Register with Polarity Coding

This block is the digital half of an 8-bit successive-approximation converter. A start pulse clears the register and places a trial code at mid-scale on the DAC-facing port. Each later step pulse resolves one bit, from the most significant down, using a single comparator input. When set, that input means the sampled input is at or above the level of the current trial code. After the last step the block latches a formatted result and pulses a valid flag for one cycle.

The result coding depends on two mode inputs, which are captured at start. With the single-ended input high, the input is taken against ground and the result is always straight binary, whatever the polarity input says. With the single-ended input low, the input is pseudo-differential. The polarity input then chooses straight binary (unipolar) or two's complement (bipolar). In unipolar mode a negative difference never beats any trial level, so it resolves to code zero. In bipolar mode the surrounding DAC is offset by half of full scale. The register then resolves an offset-binary code, and the formatter inverts its MSB to give two's complement over minus to plus half of full scale.

Top module: `sar_polar_core`

## Requirements
- R1: After reset the block is idle, with busy, result valid, the trial code and the result all zero. A start pulse makes busy high and the trial code exactly 0x80 (only bit 7 set) at the next clock edge.
- R2: Each step accepted while busy decides the bit under trial. The bit stays set if the comparator input is 1 and is cleared if it is 0. The next lower bit becomes the new trial bit, and bits already decided do not change. Exactly eight accepted steps complete a conversion.
- R3: A step pulse while idle has no effect: the trial code and the result are unchanged and no valid pulse follows.
- R4: Cycles with no start and no step leave the trial code and busy unchanged, so steps may be spaced by any number of idle cycles.
- R5: On the edge that accepts the eighth step, busy falls and the result valid output goes high for exactly one cycle, with the new result on the result port.
- R6: With the single-ended input at 1, the result is straight binary of the input measured against ground, for either value of the polarity input.
- R7: With the single-ended input at 0 and the polarity input at 0, the result is straight binary of the positive difference, and any negative difference gives 0x00.
- R8: With the single-ended input at 0 and the polarity input at 1, the result is the difference in two's complement, from 0x80 (minus half scale) to 0x7F, formed by inverting bit 7 of the resolved offset-binary code.
- R9: The two mode inputs are sampled only on the start cycle. Changes during a conversion do not alter that conversion's coding.
- R10: A start in the same cycle as a step takes priority. The conversion restarts with trial code 0x80, no valid pulse comes from the interrupted conversion, and the previous result is kept.
- R11: The result port holds its value in every cycle in which result valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion; samples the mode inputs |
| step_i | input | 1 | Resolve one bit |
| single_ended_i | input | 1 | 1: input against ground; 0: pseudo-differential |
| bipolar_i | input | 1 | 1: two's complement in differential mode |
| cmp_ge_i | input | 1 | Comparator: input at or above trial level |
| trial_code_o | output | 8 | Code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last formatted result |
| result_valid_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
A start and a step can arrive in the same cycle. The sharpest case is a start that lands on the eighth step, where completion and restart compete. The bench runs seven steps, then raises start and step together. It expects busy to stay high, the trial code to return to 0x80, no valid pulse, and the earlier result to be kept. A later full conversion must then yield the code for the new mode and input. Mode inputs that change during a conversion are also checked against the coding sampled at start.

// File: rtl/sar_polar_pkg.sv
package sar_polar_pkg;

    typedef enum logic [1:0] {
        MODE_GND_UNI  = 2'd0,
        MODE_DIFF_UNI = 2'd1,
        MODE_DIFF_BIP = 2'd2
    } code_mode_e;

    // Single-ended input forces unipolar coding.
    function automatic code_mode_e pick_mode(input logic se, input logic bip);
        if (se) begin
            return MODE_GND_UNI;
        end else if (bip) begin
            return MODE_DIFF_BIP;
        end
        return MODE_DIFF_UNI;
    endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] ptr_o,
    output logic             adv_o,
    output logic             fin_o
);
    localparam logic [WIDTH-1:0] TOP_ONEHOT = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic             busy;
        logic [WIDTH-1:0] ptr;
    } seq_s;

    seq_s seq_d, seq_q;
    logic adv;
    logic fin;

    always_comb begin
        seq_d = seq_q;
        adv   = seq_q.busy && step_i && !start_i;
        fin   = adv && seq_q.ptr[0];
        if (start_i) begin
            seq_d.busy = 1'b1;
            seq_d.ptr  = TOP_ONEHOT;
        end else if (adv) begin
            seq_d.ptr = seq_q.ptr >> 1;
            if (seq_q.ptr[0]) begin
                seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = seq_q.busy;
    assign ptr_o  = seq_q.ptr;
    assign adv_o  = adv;
    assign fin_o  = fin;

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [WIDTH-1:0] ptr_i,
    input  logic             cmp_ge_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] resolved_o
);
    logic [WIDTH-1:0] acc_d, acc_q;

    // Per-bit decision: only the bit under trial can change on a step.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign acc_d[b] = clear_i                 ? 1'b0     :
                          (adv_i && ptr_i[b])     ? cmp_ge_i :
                                                    acc_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign trial_o    = acc_q | ptr_i;
    assign resolved_o = acc_d;

endmodule

// File: rtl/sar_out_fmt.sv
module sar_out_fmt
    import sar_polar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             se_i,
    input  logic             bip_i,
    input  logic             fin_i,
    input  logic [WIDTH-1:0] code_i,
    output logic [WIDTH-1:0] result_o,
    output logic             valid_o
);
    localparam logic [WIDTH-1:0] SIGN_FLIP = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        code_mode_e       mode;
        logic [WIDTH-1:0] result;
        logic             valid;
    } fmt_s;

    fmt_s fmt_d, fmt_q;

    always_comb begin
        fmt_d       = fmt_q;
        fmt_d.valid = fin_i;
        if (start_i) begin
            fmt_d.mode = pick_mode(se_i, bip_i);
        end
        if (fin_i) begin
            if (fmt_q.mode == MODE_DIFF_BIP) begin
                fmt_d.result = code_i ^ SIGN_FLIP;
            end else begin
                fmt_d.result = code_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= '{mode: MODE_GND_UNI, result: '0, valid: 1'b0};
        end else begin
            fmt_q <= fmt_d;
        end
    end

    assign result_o = fmt_q.result;
    assign valid_o  = fmt_q.valid;

endmodule

// File: rtl/sar_polar_core.sv
module sar_polar_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             single_ended_i,
    input  logic             bipolar_i,
    input  logic             cmp_ge_i,
    output logic [WIDTH-1:0] trial_code_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] result_o,
    output logic             result_valid_o
);
    logic [WIDTH-1:0] ptr;
    logic             adv;
    logic             fin;
    logic [WIDTH-1:0] resolved;

    sar_seq_ctrl #(.WIDTH(WIDTH)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .step_i  (step_i),
        .busy_o  (busy_o),
        .ptr_o   (ptr),
        .adv_o   (adv),
        .fin_o   (fin)
    );

    sar_bit_reg #(.WIDTH(WIDTH)) bits_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .adv_i      (adv),
        .ptr_i      (ptr),
        .cmp_ge_i   (cmp_ge_i),
        .trial_o    (trial_code_o),
        .resolved_o (resolved)
    );

    sar_out_fmt #(.WIDTH(WIDTH)) fmt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .se_i     (single_ended_i),
        .bip_i    (bipolar_i),
        .fin_i    (fin),
        .code_i   (resolved),
        .result_o (result_o),
        .valid_o  (result_valid_o)
    );

endmodule

// File: rtl/sar_polar_chk.sv
module sar_polar_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             step_i,
    input logic [WIDTH-1:0] trial_code_o,
    input logic             busy_o,
    input logic [WIDTH-1:0] result_o,
    input logic             result_valid_o
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};
    localparam int CW = $clog2(WIDTH + 1) + 1;

    logic [CW-1:0] steps_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_q <= '0;
        end else if (start_i) begin
            steps_q <= '0;
        end else if (busy_o && step_i) begin
            steps_q <= steps_q + 1'b1;
        end
    end

    AST_START_LOADS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && trial_code_o == TOP_BIT)); // R1

    AST_EIGHT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> (steps_q == CW'(WIDTH))); // R2

    AST_IDLE_STEP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(trial_code_o) && !result_valid_o)); // R3

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i && !step_i) |=> ($stable(trial_code_o) && busy_o)); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o); // R5

    AST_BUSY_FALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> result_valid_o); // R5

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && step_i) |=> (!result_valid_o && busy_o)); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o)); // R11

endmodule

bind sar_polar_core sar_polar_chk #(.WIDTH(WIDTH)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .step_i         (step_i),
    .trial_code_o   (trial_code_o),
    .busy_o         (busy_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o)
);

// File: tb/sar_polar_core_tb_top.sv
`timescale 1ns/1ps
module sar_polar_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start, step, se, bip;
    logic       cmp_ge;
    logic [7:0] trial_code, result;
    logic       busy, result_valid;

    int tgt;
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Ideal comparator and DAC: analog level versus trial level.
    always_comb cmp_ge = (tgt >= int'(trial_code));

    sar_polar_core dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .step_i         (step),
        .single_ended_i (se),
        .bipolar_i      (bip),
        .cmp_ge_i       (cmp_ge),
        .trial_code_o   (trial_code),
        .busy_o         (busy),
        .result_o       (result),
        .result_valid_o (result_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int clamp8(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Analog level seen by the comparator, in trial-code units.
    function automatic int level_of(input bit s, input bit b, input int v);
        if (s) return v;
        if (b) return v + 128;
        return v;
    endfunction

    function automatic int expect_of(input bit s, input bit b, input int v);
        if (s) return clamp8(v);
        if (b) return v & 255;
        return clamp8(v);
    endfunction

    task automatic convert(input bit s, input bit b, input int v, input int gap,
                           input bit trace, input string req);
        int lvl, exp, c, mask, prev;
        lvl  = level_of(s, b, v);
        exp  = expect_of(s, b, v);
        c    = clamp8(lvl);
        prev = result;
        tgt  = lvl;
        se = s; bip = b; start = 1'b1;
        tick();
        start = 1'b0;
        if (trace) check(busy && trial_code == 8'h80, "R1", trial_code, 8'h80);
        for (int i = 0; i < 8; i++) begin
            step = 1'b1;
            tick();
            step = 1'b0;
            if (i < 7) begin
                mask = 255 & ~((1 << (7 - i)) - 1);
                if (trace) begin
                    check(int'(trial_code) == ((c & mask) | (1 << (6 - i))), "R2",
                          trial_code, (c & mask) | (1 << (6 - i)));
                    check(!result_valid && result == prev[7:0], "R11", result, prev);
                end
                for (int g = 0; g < gap; g++) begin
                    tick();
                    if (trace) check(busy && int'(trial_code) == ((c & mask) | (1 << (6 - i))),
                                     "R4", trial_code, (c & mask) | (1 << (6 - i)));
                end
            end
        end
        check(result_valid && !busy && int'(result) == exp, req, result, exp);
        tick();
        if (trace) check(!result_valid && int'(result) == exp, "R5", result_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; step = 1'b0; se = 1'b1; bip = 1'b0; tgt = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(!busy && !result_valid && result == 8'h00 && trial_code == 8'h00,
              "R1", {busy, result_valid, result}, 0);

        // R3: a step while idle does nothing
        tgt = 300; step = 1'b1;
        tick();
        step = 1'b0;
        check(trial_code == 8'h00 && !busy, "R3", trial_code, 0);
        tick();
        check(!result_valid && result == 8'h00, "R3", result, 0);

        // Traced conversions, including spaced steps
        convert(1'b1, 1'b0, 8'hA5, 0, 1'b1, "R2");
        convert(1'b0, 1'b1, -37, 2, 1'b1, "R8");
        convert(1'b0, 1'b0, 200, 1, 1'b1, "R7");

        // R3 after a completed conversion: result kept, trial unchanged
        begin
            logic [7:0] t0, r0;
            t0 = trial_code; r0 = result;
            step = 1'b1;
            tick();
            step = 1'b0;
            tick();
            check(trial_code == t0 && result == r0 && !result_valid, "R3", result, r0);
        end

        // R6: ground-referenced sweep, polarity input both ways
        for (int v = 0; v < 256; v++) convert(1'b1, 1'b0, v, 0, 1'b0, "R6");
        for (int v = 0; v < 256; v++) convert(1'b1, 1'b1, v, 0, 1'b0, "R6");
        // R7: differential unipolar, negative inputs clamp to zero
        for (int v = -255; v < 256; v++) convert(1'b0, 1'b0, v, 0, 1'b0, "R7");
        // R8: differential bipolar, full two's complement range
        for (int v = -128; v < 128; v++) convert(1'b0, 1'b1, v, 0, 1'b0, "R8");

        // R9: mode inputs changed mid-conversion are ignored
        tgt = -5 + 128;
        se = 1'b0; bip = 1'b1; start = 1'b1;
        tick();
        start = 1'b0; se = 1'b1; bip = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step = 1'b1;
            tick();
            step = 1'b0;
        end
        check(result_valid && result == 8'hFB, "R9", result, 8'hFB);
        tick();

        // R10: start coinciding with the eighth step restarts
        begin
            logic [7:0] r0;
            r0 = result;
            tgt = 90;
            se = 1'b1; bip = 1'b0; start = 1'b1;
            tick();
            start = 1'b0;
            for (int i = 0; i < 7; i++) begin
                step = 1'b1;
                tick();
            end
            tgt = -20 + 128;
            se = 1'b0; bip = 1'b1; start = 1'b1; step = 1'b1;
            tick();
            start = 1'b0; step = 1'b0;
            check(busy && trial_code == 8'h80 && !result_valid, "R10", trial_code, 8'h80);
            check(result == r0, "R10", result, r0);
            tick();
            check(!result_valid && result == r0, "R10", result, r0);
            for (int i = 0; i < 8; i++) begin
                step = 1'b1;
                tick();
                step = 1'b0;
            end
            check(result_valid && result == 8'hEC, "R10", result, 8'hEC);
            tick();
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule